// File: doc/BRIEF.md
# Pipeline Stall Cycle Accountant

This block watches the retirement stream of an in-order pipeline that can issue one instruction at a time or two as a parallel group. Each retiring instruction arrives with a base cycle cost, up to two source register indices, an optional load destination, branch and taken flags, and markers for the first and last instruction of its group. The block charges load-use penalties and taken-branch penalties, and keeps running totals of cycles, stall cycles and branch outcomes.

A 16-entry load scoreboard records which registers the previous instruction loaded. A source that reads one of those registers costs extra cycles. For a parallel group, the total cycle count grows by the larger of the two members' costs, not by their sum. The stall totals still add up every member's stalls.

Top module: `stall_acct`

## Requirements
- R1: After synchronous reset all six outputs read zero and the load scoreboard is empty.
- R2: Each source whose valid flag is high and whose 4-bit index has its bit set in the scoreboard adds 2 cycles of load stall; a source with its valid flag low adds nothing whatever its index; two hitting sources add 4.
- R3: A retiring instruction with its load flag high marks its 4-bit destination in the scoreboard, and the very next retired instruction sees that mark. An instruction marked first-of-group discards earlier marks, so a load two singles back no longer stalls. Inside a group, the second member sees the first member's load.
- R4: A branch with taken high adds 2 cycles of branch stall and increments the taken count; a branch with taken low increments only the untaken count; a non-branch changes neither count.
- R5: After every retirement the current-cycles output equals the base cycles plus the load stall plus the branch stall of that instruction.
- R6: An instruction not marked last-of-group leaves the total cycle count unchanged and stores its cost as the group maximum.
- R7: An instruction marked last-of-group adds to the total cycle count the larger of its own cost and the stored group maximum; if it is also marked first-of-group (single issue) it adds its own cost.
- R8: The load-stall and branch-stall totals add the stalls of every retired instruction, including the non-last members of a group.
- R9: Outputs change only on the clock edge that follows a cycle with the retire strobe high; all other inputs are ignored while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire | input | 1 | An instruction retires this cycle |
| base_cyc | input | 8 | Base cycle cost of the instruction |
| src0_idx | input | 4 | First source register index |
| src0_vld | input | 1 | First source is used |
| src1_idx | input | 4 | Second source register index |
| src1_vld | input | 1 | Second source is used |
| ld_vld | input | 1 | Instruction is a load |
| ld_idx | input | 4 | Load destination register |
| br_vld | input | 1 | Instruction is a branch |
| br_taken | input | 1 | Branch was taken |
| first_of_grp | input | 1 | First instruction of its issue group |
| last_of_grp | input | 1 | Last instruction of its issue group |
| total_cyc | output | 32 | Accumulated cycle count |
| cur_cyc | output | 32 | Cost of the latest retired instruction |
| ld_stall_tot | output | 32 | Accumulated load-use stall cycles |
| br_stall_tot | output | 32 | Accumulated taken-branch stall cycles |
| taken_cnt | output | 32 | Number of taken branches |
| untaken_cnt | output | 32 | Number of untaken branches |

## Verification
Every result is registered once, so an instruction's effect on all six outputs is due on the first rising edge after its retire strobe. A scoreboard mark it makes counts against the instruction retired next. The bench drives each instruction on a falling edge and holds the strobe for one cycle. It compares every output at the following falling edge, halfway between that edge and the next. Idle stretches with the other inputs toggling are sampled over several falling edges to confirm that nothing moves without the strobe.

// File: rtl/stall_acct_pkg.sv
package stall_acct_pkg;
  localparam int unsigned LOAD_PENALTY   = 2;
  localparam int unsigned BRANCH_PENALTY = 2;

  typedef struct packed {
    logic vld;
    logic taken;
  } br_info_t;
endpackage

// File: rtl/stall_acct_score.sv
module stall_acct_score #(
  parameter int IDX_W = 4,
  localparam int REGS = 2 ** IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retire,
  input  logic             first,
  input  logic             ld_vld,
  input  logic [IDX_W-1:0] ld_idx,
  output logic [REGS-1:0]  active
);
  logic [REGS-1:0] mask_nx;

  // A group's first member starts a fresh mark set; later members add to it.
  always_comb begin
    mask_nx = first ? '0 : active;
    if (ld_vld) mask_nx[ld_idx] = 1'b1;
  end

  // The marks collected so far replace the scoreboard after every retirement.
  always_ff @(posedge clk) begin
    if (rst)         active <= '0;
    else if (retire) active <= mask_nx;
  end
endmodule

// File: rtl/stall_acct_pen.sv
module stall_acct_pen
  import stall_acct_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int NSRC   = 2,
  parameter int BASE_W = 8,
  parameter int TOT_W  = BASE_W + 2,
  localparam int REGS  = 2 ** IDX_W
) (
  input  logic [REGS-1:0]            active,
  input  logic [NSRC-1:0][IDX_W-1:0] src_idx,
  input  logic [NSRC-1:0]            src_vld,
  input  br_info_t                   br,
  input  logic [BASE_W-1:0]          base,
  output logic [TOT_W-1:0]           ld_stall,
  output logic [TOT_W-1:0]           br_stall,
  output logic [TOT_W-1:0]           inst_total
);
  logic [NSRC-1:0] hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = src_vld[i] & active[src_idx[i]];
  end

  always_comb begin
    ld_stall = '0;
    for (int i = 0; i < NSRC; i++)
      if (hit[i]) ld_stall = ld_stall + TOT_W'(LOAD_PENALTY);
  end

  assign br_stall   = (br.vld && br.taken) ? TOT_W'(BRANCH_PENALTY) : '0;
  assign inst_total = TOT_W'(base) + ld_stall + br_stall;
endmodule

// File: rtl/stall_acct_accum.sv
module stall_acct_accum
  import stall_acct_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int TOT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retire,
  input  logic             first,
  input  logic             last,
  input  br_info_t         br,
  input  logic [TOT_W-1:0] inst_total,
  input  logic [TOT_W-1:0] ld_stall,
  input  logic [TOT_W-1:0] br_stall,
  output logic [CNT_W-1:0] total_cyc,
  output logic [CNT_W-1:0] cur_cyc,
  output logic [CNT_W-1:0] ld_stall_tot,
  output logic [CNT_W-1:0] br_stall_tot,
  output logic [CNT_W-1:0] taken_cnt,
  output logic [CNT_W-1:0] untaken_cnt
);
  logic [TOT_W-1:0] pair_max;
  logic [TOT_W-1:0] ref_max;
  logic [TOT_W-1:0] charge;

  assign ref_max = first ? '0 : pair_max;
  assign charge  = (inst_total > ref_max) ? inst_total : ref_max;

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_max     <= '0;
      total_cyc    <= '0;
      cur_cyc      <= '0;
      ld_stall_tot <= '0;
      br_stall_tot <= '0;
      taken_cnt    <= '0;
      untaken_cnt  <= '0;
    end else if (retire) begin
      cur_cyc      <= CNT_W'(inst_total);
      ld_stall_tot <= ld_stall_tot + CNT_W'(ld_stall);
      br_stall_tot <= br_stall_tot + CNT_W'(br_stall);
      if (last) total_cyc <= total_cyc + CNT_W'(charge);
      else      pair_max  <= inst_total;
      if (br.vld) begin
        if (br.taken) taken_cnt   <= taken_cnt + 1'b1;
        else          untaken_cnt <= untaken_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/stall_acct.sv
module stall_acct
  import stall_acct_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int BASE_W = 8,
  parameter int CNT_W  = 32,
  localparam int NSRC  = 2,
  localparam int TOT_W = BASE_W + 2,
  localparam int REGS  = 2 ** IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              retire,
  input  logic [BASE_W-1:0] base_cyc,
  input  logic [IDX_W-1:0]  src0_idx,
  input  logic              src0_vld,
  input  logic [IDX_W-1:0]  src1_idx,
  input  logic              src1_vld,
  input  logic              ld_vld,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic              br_vld,
  input  logic              br_taken,
  input  logic              first_of_grp,
  input  logic              last_of_grp,
  output logic [CNT_W-1:0]  total_cyc,
  output logic [CNT_W-1:0]  cur_cyc,
  output logic [CNT_W-1:0]  ld_stall_tot,
  output logic [CNT_W-1:0]  br_stall_tot,
  output logic [CNT_W-1:0]  taken_cnt,
  output logic [CNT_W-1:0]  untaken_cnt
);
  logic [REGS-1:0]            active;
  logic [NSRC-1:0][IDX_W-1:0] src_idx;
  logic [NSRC-1:0]            src_vld;
  br_info_t                   br;
  logic [TOT_W-1:0]           ld_stall, br_stall, inst_total;

  assign src_idx  = {src1_idx, src0_idx};
  assign src_vld  = {src1_vld, src0_vld};
  assign br.vld   = br_vld;
  assign br.taken = br_taken;

  stall_acct_score #(.IDX_W(IDX_W)) u_score (
    .clk    (clk),
    .rst    (rst),
    .retire (retire),
    .first  (first_of_grp),
    .ld_vld (ld_vld),
    .ld_idx (ld_idx),
    .active (active)
  );

  stall_acct_pen #(
    .IDX_W (IDX_W),
    .NSRC  (NSRC),
    .BASE_W(BASE_W),
    .TOT_W (TOT_W)
  ) u_pen (
    .active    (active),
    .src_idx   (src_idx),
    .src_vld   (src_vld),
    .br        (br),
    .base      (base_cyc),
    .ld_stall  (ld_stall),
    .br_stall  (br_stall),
    .inst_total(inst_total)
  );

  stall_acct_accum #(.CNT_W(CNT_W), .TOT_W(TOT_W)) u_accum (
    .clk         (clk),
    .rst         (rst),
    .retire      (retire),
    .first       (first_of_grp),
    .last        (last_of_grp),
    .br          (br),
    .inst_total  (inst_total),
    .ld_stall    (ld_stall),
    .br_stall    (br_stall),
    .total_cyc   (total_cyc),
    .cur_cyc     (cur_cyc),
    .ld_stall_tot(ld_stall_tot),
    .br_stall_tot(br_stall_tot),
    .taken_cnt   (taken_cnt),
    .untaken_cnt (untaken_cnt)
  );
endmodule

// File: rtl/stall_acct_chk.sv
module stall_acct_chk #(
  parameter int BASE_W = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              retire,
  input logic              last_of_grp,
  input logic [BASE_W-1:0] base_cyc,
  input logic [CNT_W-1:0]  total_cyc,
  input logic [CNT_W-1:0]  cur_cyc,
  input logic [CNT_W-1:0]  ld_stall_tot,
  input logic [CNT_W-1:0]  br_stall_tot,
  input logic [CNT_W-1:0]  taken_cnt,
  input logic [CNT_W-1:0]  untaken_cnt
);
  logic              armed, p_retire, p_last;
  logic [BASE_W-1:0] p_base;
  logic [CNT_W-1:0]  p_total, p_ld, p_br, p_tk, p_ut;
  logic [CNT_W-1:0]  d_total, d_ld, d_br, d_tk, d_ut;

  always_ff @(posedge clk) begin
    armed    <= !rst;
    p_retire <= retire;
    p_last   <= last_of_grp;
    p_base   <= base_cyc;
    p_total  <= total_cyc;
    p_ld     <= ld_stall_tot;
    p_br     <= br_stall_tot;
    p_tk     <= taken_cnt;
    p_ut     <= untaken_cnt;
  end

  assign d_total = total_cyc - p_total;
  assign d_ld    = ld_stall_tot - p_ld;
  assign d_br    = br_stall_tot - p_br;
  assign d_tk    = taken_cnt - p_tk;
  assign d_ut    = untaken_cnt - p_ut;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    armed && !p_retire |-> $stable(total_cyc) && $stable(cur_cyc) && $stable(ld_stall_tot)
                           && $stable(br_stall_tot) && $stable(taken_cnt) && $stable(untaken_cnt)); // R9
  AST_LOAD_STEP: assert property (@(posedge clk) disable iff (rst)
    armed |-> d_ld <= CNT_W'(4) && !d_ld[0]); // R2
  AST_BRANCH_STALL_TIE: assert property (@(posedge clk) disable iff (rst)
    armed |-> d_br == (d_tk << 1)); // R4
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    armed |-> d_tk + d_ut <= CNT_W'(1)); // R4
  AST_NONLAST_HOLD: assert property (@(posedge clk) disable iff (rst)
    armed && p_retire && !p_last |-> d_total == '0); // R6
  AST_GROUP_CHARGE: assert property (@(posedge clk) disable iff (rst)
    armed && p_retire && p_last |-> d_total >= cur_cyc); // R7
  AST_COST_FLOOR: assert property (@(posedge clk) disable iff (rst)
    armed && p_retire |-> cur_cyc >= CNT_W'(p_base)); // R5
endmodule

bind stall_acct stall_acct_chk #(.BASE_W(BASE_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .retire      (retire),
  .last_of_grp (last_of_grp),
  .base_cyc    (base_cyc),
  .total_cyc   (total_cyc),
  .cur_cyc     (cur_cyc),
  .ld_stall_tot(ld_stall_tot),
  .br_stall_tot(br_stall_tot),
  .taken_cnt   (taken_cnt),
  .untaken_cnt (untaken_cnt)
);

// File: tb/stall_acct_bench.sv
module stall_acct_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        retire = 1'b0;
  logic [7:0]  base_cyc = '0;
  logic [3:0]  src0_idx = '0, src1_idx = '0, ld_idx = '0;
  logic        src0_vld = 1'b0, src1_vld = 1'b0, ld_vld = 1'b0;
  logic        br_vld = 1'b0, br_taken = 1'b0, first_of_grp = 1'b0, last_of_grp = 1'b0;
  logic [31:0] total_cyc, cur_cyc, ld_stall_tot, br_stall_tot, taken_cnt, untaken_cnt;

  int vectors = 0;
  int miscompares = 0;

  // reference model state
  logic [15:0] m_sb = '0;
  logic [31:0] m_pmax = '0;
  logic [31:0] m_total = '0, m_cur = '0, m_ld = '0, m_br = '0, m_tk = '0, m_ut = '0;

  always #5 clk = ~clk;

  stall_acct u_stall_acct (
    .clk(clk), .rst(rst), .retire(retire), .base_cyc(base_cyc),
    .src0_idx(src0_idx), .src0_vld(src0_vld), .src1_idx(src1_idx), .src1_vld(src1_vld),
    .ld_vld(ld_vld), .ld_idx(ld_idx), .br_vld(br_vld), .br_taken(br_taken),
    .first_of_grp(first_of_grp), .last_of_grp(last_of_grp),
    .total_cyc(total_cyc), .cur_cyc(cur_cyc), .ld_stall_tot(ld_stall_tot),
    .br_stall_tot(br_stall_tot), .taken_cnt(taken_cnt), .untaken_cnt(untaken_cnt)
  );

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string ctx, input bit nonlast);
    vectors++;
    cmp(cur_cyc,      m_cur,   "R5", {ctx, " cur_cyc"});
    cmp(total_cyc,    m_total, nonlast ? "R6" : "R7", {ctx, " total_cyc"});
    cmp(ld_stall_tot, m_ld,    nonlast ? "R8" : "R2", {ctx, " ld_stall_tot"});
    cmp(br_stall_tot, m_br,    nonlast ? "R8" : "R4", {ctx, " br_stall_tot"});
    cmp(taken_cnt,    m_tk,    "R4", {ctx, " taken_cnt"});
    cmp(untaken_cnt,  m_ut,    "R4", {ctx, " untaken_cnt"});
  endtask

  task automatic issue(input int base, input int s0, input bit v0, input int s1, input bit v1,
                       input bit ldv, input int ldi, input bit brv, input bit brt,
                       input bit fst, input bit lst, input string ctx);
    int ls, bs, tot, refm;
    logic [15:0] nx;
    ls = 0;
    if (v0 && m_sb[s0]) ls += 2;
    if (v1 && m_sb[s1]) ls += 2;
    bs = (brv && brt) ? 2 : 0;
    tot = base + ls + bs;
    nx = fst ? 16'h0 : m_sb;
    if (ldv) nx[ldi] = 1'b1;
    m_sb = nx;
    if (lst) begin
      refm = fst ? 0 : int'(m_pmax);
      m_total += 32'((tot > refm) ? tot : refm);
    end else m_pmax = 32'(tot);
    m_cur = 32'(tot);
    m_ld += 32'(ls);
    m_br += 32'(bs);
    if (brv) begin
      if (brt) m_tk++;
      else     m_ut++;
    end
    @(negedge clk);
    base_cyc = 8'(base); src0_idx = 4'(s0); src0_vld = v0; src1_idx = 4'(s1); src1_vld = v1;
    ld_vld = ldv; ld_idx = 4'(ldi); br_vld = brv; br_taken = brt;
    first_of_grp = fst; last_of_grp = lst; retire = 1'b1;
    @(negedge clk);
    retire = 1'b0;
    check_all(ctx, !lst);
  endtask

  initial begin
    #(10 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 reset", 1'b0);

    // R2/R3: every load destination against every source index, in either slot
    for (int l = 0; l < 16; l++)
      for (int s = 0; s < 16; s++)
        for (int slot = 0; slot < 2; slot++) begin
          issue(1, l, 0, l, 0, 1, l, 0, 0, 1, 1, "R3 load");
          if (slot == 0) issue(3, s, 1, l, 0, 0, 0, 0, 0, 1, 1, "R2 use slot0");
          else           issue(3, l, 0, s, 1, 0, 0, 0, 0, 1, 1, "R2 use slot1");
        end

    // R2: both sources hit the same mark
    issue(1, 0, 0, 0, 0, 1, 9, 0, 0, 1, 1, "R2 load r9");
    issue(2, 9, 1, 9, 1, 0, 0, 0, 0, 1, 1, "R2 double hit");

    // R3: a mark lasts only until the next single retires
    issue(1, 0, 0, 0, 0, 1, 3, 0, 0, 1, 1, "R3 load r3");
    issue(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R3 filler");
    issue(1, 3, 1, 3, 1, 0, 0, 0, 0, 1, 1, "R3 stale mark");

    // R3: second member of a group sees the first member's load
    issue(2, 0, 0, 0, 0, 1, 5, 0, 0, 1, 0, "R3 group load");
    issue(1, 5, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R3 group use");

    // R4/R6/R7/R8: groups over costs and branch outcomes
    for (int a = 1; a <= 4; a++)
      for (int b = 1; b <= 4; b++)
        for (int k = 0; k < 4; k++) begin
          issue(a, 0, 0, 0, 0, 0, 0, 1, k[0], 1, 0, "R6 first");
          issue(b, 0, 0, 0, 0, 0, 0, k[1], 1, 0, 1, "R7 last");
        end

    // R4: non-branch with taken high counts nothing
    issue(4, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, "R4 no branch");

    // R9: no strobe, other inputs toggling
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      base_cyc = 8'(40 + i); src0_vld = 1'b1; src1_vld = 1'b1; ld_vld = 1'b1;
      br_vld = 1'b1; br_taken = i[0]; first_of_grp = i[1]; last_of_grp = i[0];
      @(negedge clk);
      check_all("R9 idle", 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule